// File: doc/BRIEF.md
# Dual-Channel Closed-Page Read Scheduler

This block sits between up to four processor cores and a shared DRAM that can serve two reads at the same time. Each core presents a request with a read/write flag and the index of the word it needs first within its cache line. Writes are taken at once by a write buffer. Reads wait in a small arrival-ordered queue and are handed to one of two independent return channels. Each channel then goes through bus arbitration and transmit setup, then the row access, then a four-beat line fill that starts with the requested word.

Because the two channels run side by side, a second read that arrives together with a first one gets its critical word in the same cycle as the first. It does not wait behind the first read's whole burst. Every row is closed and precharged after its access, so each read pays the same access time no matter what came before it. The block reports each event of a read at its ports: the grant, the command issue, every data beat (with the critical beat and the last beat marked), the core that owns the beat, and the word index of the beat.

Top module: `dual_read_sched`

## Requirements
- R1: While reset is asserted, and with no request presented, grant, command and beat outputs are all zero and the read queue is empty.
- R2: A write request is granted in the same cycle it is presented, whatever the queue occupancy, and it never causes channel activity.
- R3: A read is granted only while the queue has room, counted from occupancy at the start of the cycle. When several reads arrive in one cycle, free slots go to cores in ascending index order. A read that is not granted stays presented until it is granted.
- R4: Queued reads leave in grant order. Up to two leave per cycle, the oldest going to the lowest-numbered idle channel. A read leaves no earlier than the cycle after its grant.
- R5: A channel's command-issue pulse appears exactly 3 cycles after its read leaves the queue (4 cycles after grant when the queue and a channel are free).
- R6: The first data beat comes 8 cycles after the command. It carries the requested word index (2-bit field per channel), and later beats carry the index plus one, plus two, and plus three, modulo 4.
- R7: Each read returns exactly 4 beats on consecutive cycles on one channel, with the first beat and the last beat each marked.
- R8: Two reads granted in the same cycle on an idle block both deliver their critical word 12 cycles after grant. Neither is delayed by the other's beats.
- R9: A channel takes a new read no earlier than the cycle after its previous last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NCORES | Per-core request present |
| req_write | input | NCORES | Per-core request is a write |
| req_word | input | NCORES*WW | Per-core critical word index, WW bits each |
| grant | output | NCORES | Per-core request accepted this cycle |
| cmd_valid | output | 2 | Per-channel command issue pulse |
| cmd_core | output | 2*CW | Per-channel core index of the issued command |
| beat_valid | output | 2 | Per-channel data beat present |
| beat_first | output | 2 | Per-channel critical (first) beat marker |
| beat_last | output | 2 | Per-channel last beat marker |
| beat_core | output | 2*CW | Per-channel core index owning the beat |
| beat_word | output | 2*WW | Per-channel word index of the beat |

## Verification
A wrong queue count or a mis-ordered queue entry shows up at the grant outputs in the same cycle, as a granted read the queue had no room for or a refused one it did. It also shows a few cycles later as a command issued for the wrong core or at the wrong time. A stuck or mis-timed channel counter moves the command pulse or the beat window on that channel, so the error appears within the 15 cycles of one read. Every cycle, the bench compares all outputs against a transaction model that fixes each read's departure cycle and channel at grant time. The pair of reads granted in the same cycle has its critical-word cycles checked directly.

// File: rtl/dual_read_sched.sv
module dual_read_sched #(
  parameter int NCORES = 4,
  parameter int QDEPTH = 4,
  parameter int TARB   = 3,
  parameter int TRAC   = 8,
  parameter int BURST  = 4,
  localparam int CW = (NCORES > 1) ? $clog2(NCORES) : 1,
  localparam int WW = (BURST > 1) ? $clog2(BURST) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCORES-1:0]    req_valid,
  input  logic [NCORES-1:0]    req_write,
  input  logic [NCORES*WW-1:0] req_word,
  output logic [NCORES-1:0]    grant,
  output logic [1:0]           cmd_valid,
  output logic [2*CW-1:0]      cmd_core,
  output logic [1:0]           beat_valid,
  output logic [1:0]           beat_first,
  output logic [1:0]           beat_last,
  output logic [2*CW-1:0]      beat_core,
  output logic [2*WW-1:0]      beat_word
);
  localparam int TFIRST = TARB + TRAC - 1;
  localparam int TLAST  = TFIRST + BURST - 1;
  localparam int TW     = $clog2(TLAST + 1);
  localparam int QW     = $clog2(QDEPTH + 1);

  logic [CW-1:0] q_core [QDEPTH];
  logic [WW-1:0] q_word [QDEPTH];
  logic [QW-1:0] q_cnt;
  logic [CW-1:0] nq_core [QDEPTH];
  logic [WW-1:0] nq_word [QDEPTH];
  logic [QW-1:0] nq_cnt;

  logic [1:0]    ch_busy;
  logic [TW-1:0] ch_t    [2];
  logic [CW-1:0] ch_core [2];
  logic [WW-1:0] ch_word [2];

  logic       pop0, pop1;
  logic [1:0] load;
  logic [1:0] npop;

  always_comb begin
    int left;
    left = QDEPTH - int'(q_cnt);
    grant = '0;
    for (int i = 0; i < NCORES; i++) begin
      if (req_valid[i] && req_write[i]) grant[i] = 1'b1;
      else if (req_valid[i] && left > 0) begin
        grant[i] = 1'b1;
        left = left - 1;
      end
    end
  end

  assign pop0 = (q_cnt != '0) && (ch_busy != 2'b11);
  assign pop1 = (int'(q_cnt) >= 2) && (ch_busy == 2'b00);
  assign npop = {1'b0, pop0} + {1'b0, pop1};
  assign load[0] = pop0 && !ch_busy[0];
  assign load[1] = (pop0 && ch_busy[0]) || pop1;

  always_comb begin
    int wp;
    for (int k = 0; k < QDEPTH; k++) begin
      if (k + int'(npop) < QDEPTH) begin
        nq_core[k] = q_core[k + int'(npop)];
        nq_word[k] = q_word[k + int'(npop)];
      end else begin
        nq_core[k] = '0;
        nq_word[k] = '0;
      end
    end
    wp = int'(q_cnt) - int'(npop);
    for (int i = 0; i < NCORES; i++) begin
      if (grant[i] && !req_write[i] && wp < QDEPTH) begin
        nq_core[wp] = CW'(i);
        nq_word[wp] = req_word[i*WW +: WW];
        wp = wp + 1;
      end
    end
    nq_cnt = QW'(wp);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_cnt <= '0;
      for (int k = 0; k < QDEPTH; k++) begin
        q_core[k] <= '0;
        q_word[k] <= '0;
      end
    end else begin
      q_cnt <= nq_cnt;
      for (int k = 0; k < QDEPTH; k++) begin
        q_core[k] <= nq_core[k];
        q_word[k] <= nq_word[k];
      end
    end
  end

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [CW-1:0] src_core;
    logic [WW-1:0] src_word;
    logic [TW-1:0] beat_idx;
    assign src_core = (c == 1 && pop1) ? q_core[1] : q_core[0];
    assign src_word = (c == 1 && pop1) ? q_word[1] : q_word[0];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ch_busy[c] <= 1'b0;
        ch_t[c]    <= '0;
        ch_core[c] <= '0;
        ch_word[c] <= '0;
      end else if (load[c]) begin
        ch_busy[c] <= 1'b1;
        ch_t[c]    <= '0;
        ch_core[c] <= src_core;
        ch_word[c] <= src_word;
      end else if (ch_busy[c]) begin
        if (ch_t[c] == TW'(TLAST)) ch_busy[c] <= 1'b0;
        else ch_t[c] <= ch_t[c] + 1'b1;
      end
    end

    assign beat_idx = ch_t[c] - TW'(TFIRST);
    assign cmd_valid[c]  = ch_busy[c] && (ch_t[c] == TW'(TARB - 1));
    assign beat_valid[c] = ch_busy[c] && (ch_t[c] >= TW'(TFIRST));
    assign beat_first[c] = ch_busy[c] && (ch_t[c] == TW'(TFIRST));
    assign beat_last[c]  = ch_busy[c] && (ch_t[c] == TW'(TLAST));
    assign cmd_core[c*CW +: CW]  = ch_core[c];
    assign beat_core[c*CW +: CW] = ch_core[c];
    assign beat_word[c*WW +: WW] = ch_word[c] + beat_idx[WW-1:0];

    // R7
    last_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat_last[c] |=> !beat_valid[c]);
    // R6
    word_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid[c] && !beat_last[c]) |=> (beat_valid[c] &&
        beat_word[c*WW +: WW] == WW'($past(beat_word[c*WW +: WW]) + 1'b1) &&
        $stable(beat_core[c*CW +: CW])));
    // R7
    first_is_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat_first[c] |-> (beat_valid[c] && !$past(beat_valid[c])));
  end

  // R3
  q_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(q_cnt) <= QDEPTH);
  // R3
  grant_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(grant & ~req_write) <= QDEPTH - int'(q_cnt)) && ((grant & ~req_valid) == '0));
endmodule

// File: tb/dual_read_sched_test.sv
module dual_read_sched_test;
  localparam int NC = 4, QD = 4, TA = 3, TR = 8, BL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC-1:0] req_valid = '0, req_write = '0;
  logic [NC*2-1:0] req_word = '0;
  logic [NC-1:0] grant;
  logic [1:0] cmd_valid, beat_valid, beat_first, beat_last;
  logic [3:0] cmd_core, beat_core, beat_word;

  dual_read_sched uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_word(req_word), .grant(grant), .cmd_valid(cmd_valid), .cmd_core(cmd_core),
    .beat_valid(beat_valid), .beat_first(beat_first), .beat_last(beat_last),
    .beat_core(beat_core), .beat_word(beat_word));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, ne = 0;
  int eg[512], ed[512], ech[512], ecore[512], ewd[512];
  int chf[2] = '{0, 0};
  bit pv[NC], pw[NC];
  int pwd[NC];
  int rate = 0;
  int firstcyc[NC], firstwd[NC];
  logic [NC-1:0] lastg;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: got %0d expected %0d", req, what, cyc, act, exp);
    end
  endtask

  function automatic void add_read(int core, int wd, int g);
    int d, ch;
    d = g + 1;
    if (ne > 0 && ed[ne-1] > d) d = ed[ne-1];
    if (chf[0] > d && chf[1] > d) d = (chf[0] < chf[1]) ? chf[0] : chf[1];
    ch = (chf[0] <= d) ? 0 : 1;
    chf[ch] = d + TA + TR + BL;
    eg[ne] = g; ed[ne] = d; ech[ne] = ch; ecore[ne] = core; ewd[ne] = wd;
    ne++;
  endfunction

  task automatic step();
    int occ, left;
    logic [NC-1:0] expg;
    @(negedge clk);
    for (int i = 0; i < NC; i++) begin
      if (!pv[i] && rate > 0 && ($urandom % rate) == 0) begin
        pv[i] = 1'b1; pw[i] = (($urandom % 4) == 0); pwd[i] = $urandom % 4;
      end
      req_valid[i] = pv[i];
      req_write[i] = pw[i];
      req_word[i*2 +: 2] = 2'(pwd[i]);
    end
    #4;
    occ = 0;
    for (int j = 0; j < ne; j++) if (eg[j] < cyc && ed[j] >= cyc) occ++;
    left = QD - occ;
    expg = '0;
    for (int i = 0; i < NC; i++) begin
      if (pv[i] && pw[i]) expg[i] = 1'b1;
      else if (pv[i] && left > 0) begin
        expg[i] = 1'b1; left--;
        add_read(i, pwd[i], cyc);
      end
      chk(grant[i] == expg[i], pw[i] ? "R2" : "R3", "grant", grant[i], expg[i]);
    end
    for (int c = 0; c < 2; c++) begin
      bit ecv, ebv, ebf, ebl;
      int ecc, ebc, ebw;
      ecv = 0; ebv = 0; ebf = 0; ebl = 0; ecc = 0; ebc = 0; ebw = 0;
      for (int j = 0; j < ne; j++) begin
        if (ech[j] == c) begin
          if (ed[j] + TA == cyc) begin ecv = 1; ecc = ecore[j]; end
          if (cyc >= ed[j] + TA + TR && cyc <= ed[j] + TA + TR + BL - 1) begin
            ebv = 1; ebc = ecore[j];
            ebw = (ewd[j] + cyc - ed[j] - TA - TR) % BL;
            ebf = (cyc == ed[j] + TA + TR);
            ebl = (cyc == ed[j] + TA + TR + BL - 1);
          end
        end
      end
      chk(cmd_valid[c] == ecv, "R5/R9", "cmd_valid", cmd_valid[c], ecv);
      if (ecv) chk(cmd_core[c*2 +: 2] == ecc, "R4", "cmd_core", cmd_core[c*2 +: 2], ecc);
      chk(beat_valid[c] == ebv, "R7", "beat_valid", beat_valid[c], ebv);
      chk(beat_first[c] == ebf, "R6", "beat_first", beat_first[c], ebf);
      chk(beat_last[c] == ebl, "R7", "beat_last", beat_last[c], ebl);
      if (ebv) begin
        chk(beat_core[c*2 +: 2] == ebc, "R4", "beat_core", beat_core[c*2 +: 2], ebc);
        chk(beat_word[c*2 +: 2] == ebw, "R6", "beat_word", beat_word[c*2 +: 2], ebw);
      end
      if (beat_first[c]) begin
        firstcyc[beat_core[c*2 +: 2]] = cyc;
        firstwd[beat_core[c*2 +: 2]] = beat_word[c*2 +: 2];
      end
    end
    lastg = grant;
    for (int i = 0; i < NC; i++) if (grant[i]) pv[i] = 1'b0;
    cyc++;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int g0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NC; i++) begin pv[i] = 0; pw[i] = 0; pwd[i] = 0; firstcyc[i] = -1; end
    repeat (3) begin
      @(negedge clk);
      chk(grant == '0, "R1", "grant in reset", grant, 0);
      chk(cmd_valid == '0, "R1", "cmd_valid in reset", cmd_valid, 0);
      chk(beat_valid == '0, "R1", "beat_valid in reset", beat_valid, 0);
    end
    rst_n = 1'b1;

    // R8: two simultaneous reads on an idle block
    pv[1] = 1; pw[1] = 0; pwd[1] = 2;
    pv[3] = 1; pw[3] = 0; pwd[3] = 1;
    g0 = cyc;
    step();
    repeat (18) step();
    chk(firstcyc[1] == g0 + 12, "R8", "core1 critical cycle", firstcyc[1], g0 + 12);
    chk(firstcyc[3] == g0 + 12, "R8", "core3 critical cycle", firstcyc[3], g0 + 12);
    chk(firstwd[1] == 2, "R6", "core1 critical word", firstwd[1], 2);
    chk(firstwd[3] == 1, "R6", "core3 critical word", firstwd[3], 1);

    // R3 / R2: fill the queue, then a write still goes through
    for (int i = 0; i < NC; i++) begin pv[i] = 1; pw[i] = 0; pwd[i] = i; end
    step();
    chk(lastg == 4'hF, "R3", "four reads admitted", lastg, 15);
    pv[0] = 1; pw[0] = 0; pwd[0] = 3;
    pv[2] = 1; pw[2] = 1; pwd[2] = 0;
    step();
    chk(lastg[2] == 1'b1, "R2", "write grant with full queue", lastg[2], 1);
    chk(lastg[0] == 1'b0, "R3", "read refused with full queue", lastg[0], 0);
    repeat (60) step();

    rate = 6;
    repeat (1500) step();
    rate = 0;
    repeat (80) step();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule